// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the two timing strobes of a multiplexed external memory bus: an active-high address latch strobe (`ale_o`) and an active-low program-read strobe (`psen_n_o`). It runs on the oscillator clock. Every 12 oscillator periods form one machine cycle, made of six states of two phases each. The block publishes the current state and phase so that neighbouring logic can align its own actions to the same grid.

At the first clock of each machine cycle, the block captures four things from its inputs: whether code is being fetched from external program memory, whether this cycle carries an external data transfer, whether the address strobe is restricted to data transfers, and the power mode. These captured values govern the whole cycle. In normal running the address strobe pulses twice per machine cycle, which is one sixth of the oscillator rate. The read strobe drops twice per cycle while code comes from outside. A data-transfer cycle drops the second address pulse and both read pulses, and normal pulsing resumes in the next cycle. In idle both strobes are parked high. In power-down both are parked low.

Top module: `xbus_strobe_seq`

## Requirements
- R1: While `rst` is high, `ale_o` is 0, `psen_n_o` is 1, `state_idx_o` is 5 and `phase_idx_o` is 1. The first clock after release starts a machine cycle at state 0, phase 0.
- R2: The phase index counts 0,1 and the state index counts 0..5, advancing the state when the phase wraps. A machine cycle therefore lasts exactly 12 clocks.
- R3: In run mode (`pwr_mode_i` = 2'b00), in a cycle that is not a data cycle and not gated, `ale_o` is high during all of state 0 and all of state 3, and low otherwise. This gives two pulses of two clocks each per cycle.
- R4: In run mode with `ext_code_i` captured high and no data cycle, `psen_n_o` is low in state 1 phase 1, state 2, state 4 phase 1 and state 5, and high otherwise. `ale_o` has therefore been low for at least one clock whenever `psen_n_o` falls.
- R5: In run mode with `ext_code_i` captured low, `psen_n_o` stays high for the whole cycle.
- R6: In a run-mode cycle with `xdata_cyc_i` captured high, the state-0 address pulse is kept and the state-3 pulse is suppressed. The next cycle pulses normally.
- R7: In a run-mode cycle with `xdata_cyc_i` captured high, `psen_n_o` stays high for the whole cycle.
- R8: With `ale_gate_i` captured high, `ale_o` stays low in cycles that are not data cycles. In a data cycle it gives only the state-0 pulse.
- R9: In idle (`pwr_mode_i` = 2'b01), `ale_o` and `psen_n_o` are both held high for the whole cycle.
- R10: In power-down (`pwr_mode_i` = 2'b10 or 2'b11), `ale_o` and `psen_n_o` are both held low for the whole cycle.
- R11: The inputs are sampled only on the clock edge that begins a machine cycle. A change at any other edge has no effect on the strobes until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_code_i | input | 1 | Code is fetched from external program memory |
| xdata_cyc_i | input | 1 | This machine cycle performs an external data transfer |
| ale_gate_i | input | 1 | Restrict the address strobe to data cycles |
| pwr_mode_i | input | 2 | 00 run, 01 idle, 10/11 power-down |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program read strobe, active low |
| state_idx_o | output | 3 | Current state within the machine cycle (0..5) |
| phase_idx_o | output | 1 | Current phase within the state (0..1) |

## Verification
The hardest situation to reach from the ports is an input that changes in the middle of a machine cycle. This includes a switch into power-down or the raising of the data flag part-way through, which the strobes must ignore until the next boundary. The random phase redraws every input at each boundary and, on about one clock in eight, scrambles them inside the cycle. A directed case also switches from run to power-down just after a boundary. Pulse counts per cycle are tallied on the bench side and compared with the 2/1/0 rates for each mode. Gated data cycles and mode switches that follow one another are included.

// File: rtl/xbus_strobe_pkg.sv
package xbus_strobe_pkg;

  typedef enum logic [1:0] {
    PM_RUN      = 2'b00,
    PM_IDLE     = 2'b01,
    PM_HALT     = 2'b10,
    PM_HALT_ALT = 2'b11
  } pwr_mode_e;

  // Per-machine-cycle control, captured once at the cycle boundary.
  typedef struct packed {
    logic      ext_code;
    logic      xdata;
    logic      ale_gate;
    pwr_mode_e mode;
  } cyc_flags_t;

  // Two address pulses (and two read windows) per machine cycle.
  localparam int N_PULSE_SLOTS = 2;

endpackage

// File: rtl/xbus_timebase.sv
module xbus_timebase #(
  parameter int N_STATES      = 6,
  parameter int CLK_PER_STATE = 2,
  localparam int ST_W = $clog2(N_STATES),
  localparam int PH_W = $clog2(CLK_PER_STATE)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [ST_W-1:0] st_q,
  output logic [ST_W-1:0] st_d,
  output logic [PH_W-1:0] ph_q,
  output logic [PH_W-1:0] ph_d,
  output logic            cyc_end
);

  localparam logic [ST_W-1:0] ST_LAST = ST_W'(N_STATES - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_STATE - 1);

  always_comb begin
    cyc_end = (st_q == ST_LAST) && (ph_q == PH_LAST);
    if (ph_q == PH_LAST) begin
      ph_d = '0;
      st_d = (st_q == ST_LAST) ? '0 : st_q + 1'b1;
    end else begin
      ph_d = ph_q + 1'b1;
      st_d = st_q;
    end
  end

  // Reset parks on the last phase so the first live edge opens a cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_LAST;
      ph_q <= PH_LAST;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

endmodule

// File: rtl/xbus_cycle_latch.sv
module xbus_cycle_latch
  import xbus_strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  cyc_flags_t flags_in,
  output cyc_flags_t flags_q,
  output cyc_flags_t flags_nxt
);

  // Hold for the whole machine cycle; refresh only at its boundary.
  always_comb flags_nxt = load ? flags_in : flags_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_nxt;
  end

endmodule

// File: rtl/xbus_strobe_decode.sv
module xbus_strobe_decode
  import xbus_strobe_pkg::*;
#(
  parameter int N_STATES      = 6,
  parameter int CLK_PER_STATE = 2,
  parameter int SLOT_GAP      = 3,
  localparam int ST_W = $clog2(N_STATES),
  localparam int PH_W = $clog2(CLK_PER_STATE)
) (
  input  logic [ST_W-1:0] st,
  input  logic [PH_W-1:0] ph,
  input  cyc_flags_t      fl,
  output logic            ale,
  output logic            psen_n
);

  logic [N_PULSE_SLOTS-1:0] ale_hit;
  logic [N_PULSE_SLOTS-1:0] ale_keep;
  logic [N_PULSE_SLOTS-1:0] rd_hit;

  for (genvar k = 0; k < N_PULSE_SLOTS; k++) begin : g_slot
    localparam logic [ST_W-1:0] S_ALE = ST_W'(k * SLOT_GAP);
    localparam logic [ST_W-1:0] S_RD0 = ST_W'(k * SLOT_GAP + 1);
    localparam logic [ST_W-1:0] S_RD1 = ST_W'(k * SLOT_GAP + 2);

    // Address strobe owns a whole state; the read window opens one phase
    // after it falls and runs to the end of the following state.
    assign ale_hit[k] = (st == S_ALE);
    assign rd_hit[k]  = ((st == S_RD0) && (ph != '0)) || (st == S_RD1);

    if (k == 0) begin : g_lead
      // Leading pulse carries the data address, so it survives gating.
      assign ale_keep[k] = !fl.ale_gate || fl.xdata;
    end else begin : g_trail
      assign ale_keep[k] = !fl.ale_gate && !fl.xdata;
    end
  end

  always_comb begin
    unique case (fl.mode)
      PM_IDLE: begin
        ale    = 1'b1;
        psen_n = 1'b1;
      end
      PM_HALT, PM_HALT_ALT: begin
        ale    = 1'b0;
        psen_n = 1'b0;
      end
      default: begin
        ale    = |(ale_hit & ale_keep);
        psen_n = !(fl.ext_code && !fl.xdata && (|rd_hit));
      end
    endcase
  end

endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq
  import xbus_strobe_pkg::*;
#(
  parameter int N_STATES      = 6,
  parameter int CLK_PER_STATE = 2,
  localparam int ST_W = $clog2(N_STATES),
  localparam int PH_W = $clog2(CLK_PER_STATE)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_code_i,
  input  logic            xdata_cyc_i,
  input  logic            ale_gate_i,
  input  logic [1:0]      pwr_mode_i,
  output logic            ale_o,
  output logic            psen_n_o,
  output logic [ST_W-1:0] state_idx_o,
  output logic [PH_W-1:0] phase_idx_o
);

  localparam int SLOT_GAP = N_STATES / N_PULSE_SLOTS;

  logic [ST_W-1:0] st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            cyc_end;
  cyc_flags_t      flags_in, flags_q, flags_nxt;
  logic            ale_d, psen_n_d;
  logic            ale_q, psen_n_q;

  xbus_timebase #(
    .N_STATES      (N_STATES),
    .CLK_PER_STATE (CLK_PER_STATE)
  ) u_time (
    .clk     (clk),
    .rst     (rst),
    .st_q    (st_q),
    .st_d    (st_d),
    .ph_q    (ph_q),
    .ph_d    (ph_d),
    .cyc_end (cyc_end)
  );

  always_comb begin
    flags_in.ext_code = ext_code_i;
    flags_in.xdata    = xdata_cyc_i;
    flags_in.ale_gate = ale_gate_i;
    flags_in.mode     = pwr_mode_e'(pwr_mode_i);
  end

  xbus_cycle_latch u_flags (
    .clk       (clk),
    .rst       (rst),
    .load      (cyc_end),
    .flags_in  (flags_in),
    .flags_q   (flags_q),
    .flags_nxt (flags_nxt)
  );

  // Decode from next-state values so the registered strobes line up with
  // the registered state/phase index in the same clock.
  xbus_strobe_decode #(
    .N_STATES      (N_STATES),
    .CLK_PER_STATE (CLK_PER_STATE),
    .SLOT_GAP      (SLOT_GAP)
  ) u_dec (
    .st     (st_d),
    .ph     (ph_d),
    .fl     (flags_nxt),
    .ale    (ale_d),
    .psen_n (psen_n_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q    <= 1'b0;
      psen_n_q <= 1'b1;
    end else begin
      ale_q    <= ale_d;
      psen_n_q <= psen_n_d;
    end
  end

  assign ale_o       = ale_q;
  assign psen_n_o    = psen_n_q;
  assign state_idx_o = st_q;
  assign phase_idx_o = ph_q;

endmodule

// File: rtl/xbus_strobe_seq_chk.sv
module xbus_strobe_seq_chk #(
  parameter int N_STATES      = 6,
  parameter int CLK_PER_STATE = 2,
  localparam int ST_W = $clog2(N_STATES),
  localparam int PH_W = $clog2(CLK_PER_STATE)
) (
  input logic            clk,
  input logic            rst,
  input logic            ale,
  input logic            psen_n,
  input logic [ST_W-1:0] st_idx,
  input logic [PH_W-1:0] ph_idx,
  input logic            f_ext,
  input logic            f_data,
  input logic            f_gate,
  input logic [1:0]      f_mode
);

  localparam logic [ST_W-1:0] ST_LAST = ST_W'(N_STATES - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_STATE - 1);
  localparam logic [ST_W-1:0] SLOT_B  = ST_W'(N_STATES / 2);

  logic run_m;
  assign run_m = (f_mode == 2'b00);

  p_reset_out_r1: assert property (@(posedge clk)
    rst |=> (!ale && psen_n));

  p_cycle_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (st_idx == ST_LAST && ph_idx == PH_LAST) |=> (st_idx == '0 && ph_idx == '0));

  p_state_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ph_idx == PH_LAST && st_idx != ST_LAST) |=> (st_idx == $past(st_idx) + 1'b1));

  p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ph_idx != PH_LAST) |=> (ph_idx == $past(ph_idx) + 1'b1 && $stable(st_idx)));

  p_ale_width_r3: assert property (@(posedge clk) disable iff (rst)
    (run_m && $rose(ale)) |=> ale);

  p_ale_end_r3: assert property (@(posedge clk) disable iff (rst)
    (run_m && ale && ph_idx == PH_LAST && st_idx != ST_LAST) |=> !ale);

  p_ale_before_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (run_m && $fell(psen_n)) |-> (!ale && !$past(ale)));

  p_int_no_rd_r5: assert property (@(posedge clk) disable iff (rst)
    (run_m && !f_ext) |-> psen_n);

  p_data_no_late_ale_r6: assert property (@(posedge clk) disable iff (rst)
    (run_m && f_data && st_idx >= SLOT_B) |-> !ale);

  p_data_no_rd_r7: assert property (@(posedge clk) disable iff (rst)
    (run_m && f_data) |-> psen_n);

  p_gate_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (run_m && f_gate && !f_data) |-> !ale);

  p_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
    (f_mode == 2'b01) |-> (ale && psen_n));

  p_pdown_low_r10: assert property (@(posedge clk) disable iff (rst)
    f_mode[1] |-> (!ale && !psen_n));

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(st_idx == '0 && ph_idx == '0) |-> $stable({f_ext, f_data, f_gate, f_mode}));

endmodule

bind xbus_strobe_seq xbus_strobe_seq_chk #(
  .N_STATES      (N_STATES),
  .CLK_PER_STATE (CLK_PER_STATE)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ale    (ale_o),
  .psen_n (psen_n_o),
  .st_idx (state_idx_o),
  .ph_idx (phase_idx_o),
  .f_ext  (flags_q.ext_code),
  .f_data (flags_q.xdata),
  .f_gate (flags_q.ale_gate),
  .f_mode (flags_q.mode)
);

// File: tb/xbus_strobe_seq_test.sv
module xbus_strobe_seq_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       ext_code_i, xdata_cyc_i, ale_gate_i;
  logic [1:0] pwr_mode_i;
  logic       ale_o, psen_n_o;
  logic [2:0] state_idx_o;
  logic [0:0] phase_idx_o;

  always #4 clk = ~clk;

  xbus_strobe_seq uut (
    .clk         (clk),
    .rst         (rst),
    .ext_code_i  (ext_code_i),
    .xdata_cyc_i (xdata_cyc_i),
    .ale_gate_i  (ale_gate_i),
    .pwr_mode_i  (pwr_mode_i),
    .ale_o       (ale_o),
    .psen_n_o    (psen_n_o),
    .state_idx_o (state_idx_o),
    .phase_idx_o (phase_idx_o)
  );

  int   checks = 0;
  int   fails  = 0;
  logic done   = 1'b0;

  // Reference model state
  int         m_cnt = 11;
  logic       m_e = 0, m_d = 0, m_a = 0;
  logic [1:0] m_m = 2'b00;
  logic       m_rst = 1'b1;
  logic       mid_chg = 1'b0;
  logic       exp_ale = 1'b0, exp_psen = 1'b1;
  int         ale_rises = 0, rd_falls = 0;
  logic       prev_ale = 1'b0, prev_psen = 1'b1, prev_run = 1'b0;

  function automatic string ale_tag();
    string t;
    if (m_rst)               t = "R1";
    else if (m_m[1])         t = "R10";
    else if (m_m == 2'b01)   t = "R9";
    else if (m_a && !m_d)    t = "R8";
    else if (m_d)            t = "R6";
    else                     t = "R3";
    return mid_chg ? {"R11 ", t} : t;
  endfunction

  function automatic string rd_tag();
    string t;
    if (m_rst)               t = "R1";
    else if (m_m[1])         t = "R10";
    else if (m_m == 2'b01)   t = "R9";
    else if (!m_e)           t = "R5";
    else if (m_d)            t = "R7";
    else                     t = "R4";
    return mid_chg ? {"R11 ", t} : t;
  endfunction

  // Expected strobes for counter value c under the latched flags.
  function automatic logic f_ale(int c);
    int st = c / 2;
    if (m_m == 2'b01) return 1'b1;
    if (m_m[1])       return 1'b0;
    if (st == 0) return !m_a || m_d;
    if (st == 3) return !m_a && !m_d;
    return 1'b0;
  endfunction

  function automatic logic f_psen(int c);
    logic win = (c >= 3 && c <= 5) || (c >= 9 && c <= 11);
    if (m_m == 2'b01) return 1'b1;
    if (m_m[1])       return 1'b0;
    return !(m_e && !m_d && win);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(logic e, logic d, logic a, logic [1:0] m, logic r);
    ext_code_i  = e;
    xdata_cyc_i = d;
    ale_gate_i  = a;
    pwr_mode_i  = m;
    rst         = r;
    m_rst       = r;
    if (r) begin
      m_cnt = 11; exp_ale = 1'b0; exp_psen = 1'b1; mid_chg = 1'b0;
    end else begin
      if (m_cnt == 11) begin
        m_cnt = 0; m_e = e; m_d = d; m_a = a; m_m = m; mid_chg = 1'b0;
      end else begin
        if (e != m_e || d != m_d || a != m_a || m != m_m) mid_chg = 1'b1;
        m_cnt++;
      end
      exp_ale  = f_ale(m_cnt);
      exp_psen = f_psen(m_cnt);
    end
    @(negedge clk);
    chk(r ? "R1" : "R2", "state", int'(state_idx_o), m_cnt / 2);
    chk(r ? "R1" : "R2", "phase", int'(phase_idx_o), m_cnt % 2);
    chk(ale_tag(), "ale", int'(ale_o), int'(exp_ale));
    chk(rd_tag(), "psen_n", int'(psen_n_o), int'(exp_psen));
    if (r) begin
      ale_rises = 0; rd_falls = 0; prev_run = 1'b0;
      prev_ale = 1'b0; prev_psen = 1'b1;
    end else begin
      if (ale_o && !prev_ale)    ale_rises++;
      if (!psen_n_o && prev_psen) rd_falls++;
      prev_ale  = ale_o;
      prev_psen = psen_n_o;
      if (m_cnt == 11) begin
        if (m_m == 2'b00 && prev_run) begin
          chk(m_a ? "R8" : (m_d ? "R6" : "R3"), "ale pulses per cycle",
              ale_rises, m_a ? (m_d ? 1 : 0) : (m_d ? 1 : 2));
          chk(!m_e ? "R5" : (m_d ? "R7" : "R4"), "psen pulses per cycle",
              rd_falls, (m_e && !m_d) ? 2 : 0);
        end
        prev_run  = (m_m == 2'b00);
        ale_rises = 0;
        rd_falls  = 0;
      end
    end
  endtask

  task automatic cycles(logic e, logic d, logic a, logic [1:0] m, int n);
    for (int i = 0; i < n * 12; i++) step(e, d, a, m, 1'b0);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240);
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
    cycles(1, 0, 0, 2'b00, 3);   // R3 R4 external fetch
    cycles(0, 0, 0, 2'b00, 2);   // R5 internal fetch
    cycles(1, 1, 0, 2'b00, 1);   // R6 R7 data cycle
    cycles(1, 0, 0, 2'b00, 1);   // resume
    cycles(1, 0, 1, 2'b00, 2);   // R8 gated, no data
    cycles(1, 1, 1, 2'b00, 1);   // R8 gated data cycle
    cycles(1, 0, 0, 2'b00, 1);
    cycles(1, 0, 0, 2'b01, 2);   // R9 idle
    cycles(1, 0, 0, 2'b10, 2);   // R10 power-down
    cycles(0, 0, 0, 2'b11, 1);   // R10 alternate code
    cycles(1, 0, 0, 2'b00, 2);
    // R11: switch inputs just after a boundary; no effect until next cycle
    step(1, 0, 0, 2'b00, 1'b0);
    for (int i = 0; i < 11; i++) step(0, 1, 1, 2'b10, 1'b0);
    cycles(1, 0, 0, 2'b00, 1);
    // R1: reset in mid-cycle
    for (int i = 0; i < 5; i++) step(1, 0, 0, 2'b00, 1'b0);
    for (int i = 0; i < 2; i++) step(1, 0, 0, 2'b00, 1'b1);
    cycles(1, 0, 0, 2'b00, 2);
    // Random phase
    for (int c = 0; c < 300; c++) begin
      logic e, d, a;
      logic [1:0] m;
      int r;
      e = 1'($urandom % 2);
      d = 1'(($urandom % 3) == 0);
      a = 1'(($urandom % 4) == 0);
      r = int'($urandom % 10);
      m = (r < 7) ? 2'b00 : (r < 8) ? 2'b01 : (r < 9) ? 2'b10 : 2'b11;
      for (int k = 0; k < 12; k++) begin
        if (k != 0 && ($urandom % 8) == 0)
          step(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 2'($urandom % 4), 1'b0);
        else
          step(e, d, a, m, 1'b0);
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule